// File: doc/BRIEF.md
# Three-Rail Supervisor with Hiccup Retry

This block is the digital supervisor for a group of step-down converter rails. It takes per-rail comparator flags, an enable level, a die-temperature alarm and an input-supply-low flag, and from them it drives the rail enables, a per-rail high-side switch inhibit, a soft-start indication and an active-high power-good level. All rails are started, stopped and retried together as one group.

Every duration is counted in ticks from an internal prescaler, so the same logic runs with real millisecond and second values in silicon and with short counts in simulation. The temperature alarm and the input-low flag each pass through a tick-based glitch filter. Power-good needs the start-up sequence to be finished, a filtered rail status and a long reset hold time. A rail that stays under its low threshold for a set time makes the block switch all rails off, wait for a set time and then start them again.

Top module: `rail_supervisor`

## Requirements
- R1: While reset is held, all rail enables, all switch inhibits, the soft-start indication and power-good are low.
- R2: When enable is high and neither filtered fault is active, all rail enables rise together one clock after the idle state is left. The soft-start indication is high for T_SS ticks, and then the block enters its run state.
- R3: Power-good rises only in the run state. The rail status is good when every rail's in-regulation flag is high, and it stays good until some rail's undervoltage flag is high. That status must be good for T_PG_DG ticks, and after that the reset hold of T_RESET ticks must pass. Soft-start is never high while power-good is high.
- R4: Power-good falls when the rail status has been bad for T_PG_DG ticks. A bad status that is shorter than that leaves power-good high.
- R5: In the run state, if any rail undervoltage flag stays high for T_HIC_ON ticks, all rail enables go low. A shorter undervoltage pulse does not turn the rails off.
- R6: After a hiccup shutdown, the rails stay off for T_HIC_OFF ticks and then restart with a new soft-start.
- R7: Each rail's high-side inhibit goes high one clock after its upper overvoltage flag is high. It stays high while the lower overvoltage flag is still high, and it clears one clock after both flags are low. Rails do not affect each other. The lower flag alone does not set the inhibit.
- R8: A temperature alarm that stays high for T_THERM_DG ticks turns all rails off and clears power-good. A shorter pulse is ignored. Once the alarm has been low for T_THERM_DG ticks, a new start-up begins without any other action.
- R9: The input-low flag is filtered over T_UVLO_DG ticks on both edges. After reset it counts as active, so start-up waits until the flag has been low for that long. Once it has been high for that long, all rails turn off.
- R10: When enable is low, the next clock has all rail enables low and power-good low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable_i | input | 1 | Group enable level |
| therm_hot_i | input | 1 | Die temperature alarm, 1 = too hot |
| vin_low_i | input | 1 | Input supply below lockout level |
| rail_uv_i | input | N_RAIL | Per rail: output below low (falling) threshold |
| rail_ok_i | input | N_RAIL | Per rail: output above in-regulation (rising) threshold |
| rail_ovh_i | input | N_RAIL | Per rail: output above upper overvoltage level |
| rail_ovl_i | input | N_RAIL | Per rail: output above lower overvoltage release level |
| rail_en_o | output | N_RAIL | Per-rail converter enable |
| hs_off_o | output | N_RAIL | Per-rail high-side switch inhibit |
| softstart_o | output | 1 | Soft-start interval in progress |
| power_ok_o | output | 1 | Power-good, active high |

## Verification
The overvoltage inhibit and the response to enable are due exactly one clock after the stimulus, so those checks sample at the falling edge after that one clock. Every tick-based result changes at an edge that depends on the phase of the prescaler. For N ticks plus L register stages, that edge falls between (N-1)·P+1+L and N·P+L clocks after the stimulus, where P is the prescale ratio. The bench counts clocks from the stimulus, or from the edge that started the interval, until the output changes, and it requires the count to lie inside that window. Glitch-rejection checks watch the outputs on every clock over several filter lengths.

// File: rtl/rail_sup_pkg.sv
package rail_sup_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_SOFT = 2'd1,
      ST_RUN  = 2'd2,
      ST_HOFF = 2'd3
   } seq_state_t;
endpackage

// File: rtl/sup_prescaler.sv
module sup_prescaler #(
   parameter int DIV = 1000
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick_o
);
   initial begin : p_param_check
      if (DIV < 1) $error("sup_prescaler: DIV must be at least 1");
   end

   generate
      if (DIV == 1) begin : g_pass
         assign tick_o = 1'b1;
      end else begin : g_count
         localparam int W = $clog2(DIV);
         localparam logic [W-1:0] LAST = W'(DIV - 1);
         logic [W-1:0] cnt_q;

         always_ff @(posedge clk) begin
            if (!rst_n)              cnt_q <= '0;
            else if (cnt_q == LAST)  cnt_q <= '0;
            else                     cnt_q <= cnt_q + 1'b1;
         end

         assign tick_o = (cnt_q == LAST);
      end
   endgenerate
endmodule

// File: rtl/sup_timer.sv
module sup_timer #(
   parameter int LIMIT = 600
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   input  logic tick_i,
   output logic done_o
);
   localparam int W = $clog2(LIMIT + 1);
   localparam logic [W-1:0] END_CNT = W'(LIMIT);

   initial begin : p_param_check
      if (LIMIT < 1) $error("sup_timer: LIMIT must be at least 1");
   end

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)                          cnt_q <= '0;
      else if (clr_i)                      cnt_q <= '0;
      else if (tick_i && cnt_q != END_CNT) cnt_q <= cnt_q + 1'b1;
   end

   assign done_o = (cnt_q == END_CNT);

   AST_TMR_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) cnt_q <= END_CNT); // R6
endmodule

// File: rtl/sup_deglitch.sv
module sup_deglitch #(
   parameter int TICKS = 22,
   parameter bit INIT  = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   input  logic tick_i,
   input  logic raw_i,
   output logic filt_o
);
   localparam int W = $clog2(TICKS + 1);
   localparam logic [W-1:0] LAST = W'(TICKS - 1);

   initial begin : p_param_check
      if (TICKS < 1) $error("sup_deglitch: TICKS must be at least 1");
   end

   logic [W-1:0] cnt_q;
   logic         filt_q;

   always_ff @(posedge clk) begin
      if (!rst_n || clr_i) begin
         filt_q <= INIT;
         cnt_q  <= '0;
      end else if (raw_i == filt_q) begin
         cnt_q  <= '0;
      end else if (tick_i) begin
         if (cnt_q == LAST) begin
            filt_q <= raw_i;
            cnt_q  <= '0;
         end else begin
            cnt_q  <= cnt_q + 1'b1;
         end
      end
   end

   assign filt_o = filt_q;

   AST_DG_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(filt_q) |-> ($past(tick_i) || $past(clr_i))); // R4
endmodule

// File: rtl/sup_seq_fsm.sv
module sup_seq_fsm
   import rail_sup_pkg::*;
#(
   parameter int N_RAIL    = 3,
   parameter int T_SS      = 600,
   parameter int T_HIC_ON  = 2400,
   parameter int T_HIC_OFF = 3000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic              shutdown_i,
   input  logic              uv_any_i,
   output logic [N_RAIL-1:0] rail_en_o,
   output logic              softstart_o,
   output logic              run_o
);
   seq_state_t state_q, state_d;
   logic ss_done, hon_done, hoff_done;

   sup_timer #(.LIMIT(T_SS)) u_ss_tmr (
      .clk(clk), .rst_n(rst_n), .clr_i(state_q != ST_SOFT),
      .tick_i(tick_i), .done_o(ss_done));

   sup_timer #(.LIMIT(T_HIC_ON)) u_hon_tmr (
      .clk(clk), .rst_n(rst_n), .clr_i(!(state_q == ST_RUN && uv_any_i)),
      .tick_i(tick_i), .done_o(hon_done));

   sup_timer #(.LIMIT(T_HIC_OFF)) u_hoff_tmr (
      .clk(clk), .rst_n(rst_n), .clr_i(state_q != ST_HOFF),
      .tick_i(tick_i), .done_o(hoff_done));

   always_comb begin
      state_d = state_q;
      if (shutdown_i) begin
         state_d = ST_IDLE;
      end else begin
         case (state_q)
            ST_IDLE: state_d = ST_SOFT;
            ST_SOFT: if (ss_done)   state_d = ST_RUN;
            ST_RUN:  if (hon_done)  state_d = ST_HOFF;
            ST_HOFF: if (hoff_done) state_d = ST_SOFT;
            default: state_d = ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state_q <= ST_IDLE;
      else        state_q <= state_d;
   end

   assign rail_en_o   = {N_RAIL{state_q == ST_SOFT || state_q == ST_RUN}};
   assign softstart_o = (state_q == ST_SOFT);
   assign run_o       = (state_q == ST_RUN);

   AST_SHUTDOWN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      shutdown_i |=> state_q == ST_IDLE); // R8
   AST_IDLE_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
      state_q == ST_IDLE |=> (state_q != ST_RUN && state_q != ST_HOFF)); // R2
   AST_HOFF_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
      state_q == ST_HOFF |=> state_q != ST_RUN); // R6
endmodule

// File: rtl/rail_supervisor.sv
module rail_supervisor #(
   parameter int N_RAIL     = 3,
   parameter int PRESCALE   = 1000,
   parameter int T_SS       = 600,
   parameter int T_PG_DG    = 2200,
   parameter int T_RESET    = 200000,
   parameter int T_HIC_ON   = 2400,
   parameter int T_HIC_OFF  = 3000,
   parameter int T_THERM_DG = 22,
   parameter int T_UVLO_DG  = 22
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable_i,
   input  logic              therm_hot_i,
   input  logic              vin_low_i,
   input  logic [N_RAIL-1:0] rail_uv_i,
   input  logic [N_RAIL-1:0] rail_ok_i,
   input  logic [N_RAIL-1:0] rail_ovh_i,
   input  logic [N_RAIL-1:0] rail_ovl_i,
   output logic [N_RAIL-1:0] rail_en_o,
   output logic [N_RAIL-1:0] hs_off_o,
   output logic              softstart_o,
   output logic              power_ok_o
);
   initial begin : p_param_check
      if (N_RAIL < 1) $error("rail_supervisor: N_RAIL must be at least 1");
   end

   logic tick, therm_f, vin_f, shutdown, run;
   logic status_q, good_f, hold_done;

   sup_prescaler #(.DIV(PRESCALE)) u_presc (
      .clk(clk), .rst_n(rst_n), .tick_o(tick));

   sup_deglitch #(.TICKS(T_THERM_DG), .INIT(1'b0)) u_therm_dg (
      .clk(clk), .rst_n(rst_n), .clr_i(1'b0), .tick_i(tick),
      .raw_i(therm_hot_i), .filt_o(therm_f));

   sup_deglitch #(.TICKS(T_UVLO_DG), .INIT(1'b1)) u_vin_dg (
      .clk(clk), .rst_n(rst_n), .clr_i(1'b0), .tick_i(tick),
      .raw_i(vin_low_i), .filt_o(vin_f));

   assign shutdown = !enable_i || therm_f || vin_f;

   sup_seq_fsm #(
      .N_RAIL(N_RAIL), .T_SS(T_SS), .T_HIC_ON(T_HIC_ON), .T_HIC_OFF(T_HIC_OFF)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .tick_i(tick), .shutdown_i(shutdown),
      .uv_any_i(|rail_uv_i), .rail_en_o(rail_en_o),
      .softstart_o(softstart_o), .run_o(run));

   // Rail status with hysteresis: low flag wins, all-in-regulation sets.
   always_ff @(posedge clk) begin
      if (!rst_n)           status_q <= 1'b0;
      else if (|rail_uv_i)  status_q <= 1'b0;
      else if (&rail_ok_i)  status_q <= 1'b1;
   end

   sup_deglitch #(.TICKS(T_PG_DG), .INIT(1'b0)) u_pg_dg (
      .clk(clk), .rst_n(rst_n), .clr_i(!run), .tick_i(tick),
      .raw_i(status_q), .filt_o(good_f));

   sup_timer #(.LIMIT(T_RESET)) u_hold_tmr (
      .clk(clk), .rst_n(rst_n), .clr_i(!(run && good_f)),
      .tick_i(tick), .done_o(hold_done));

   assign power_ok_o = run && good_f && hold_done;

   generate
      for (genvar r = 0; r < N_RAIL; r++) begin : g_ov
         logic inhib_q;
         always_ff @(posedge clk) begin
            if (!rst_n) inhib_q <= 1'b0;
            else        inhib_q <= rail_ovh_i[r] || (inhib_q && rail_ovl_i[r]);
         end
         assign hs_off_o[r] = inhib_q;

         AST_OV_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
            rail_ovh_i[r] |=> hs_off_o[r]); // R7
         AST_OV_FREE: assert property (@(posedge clk) disable iff (!rst_n)
            (!rail_ovh_i[r] && !rail_ovl_i[r]) |=> !hs_off_o[r]); // R7
      end
   endgenerate

   AST_EN_DROP_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !enable_i |=> (rail_en_o == '0 && !power_ok_o)); // R10
   AST_PG_AFTER_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
      power_ok_o |-> (!softstart_o && (&rail_en_o))); // R3
endmodule

// File: tb/rail_supervisor_tb.sv
module rail_supervisor_tb;
   localparam int CLK_PERIOD = 10;
   localparam int P      = 2;
   localparam int T_SS   = 5;
   localparam int T_PGD  = 4;
   localparam int T_RP   = 10;
   localparam int T_HON  = 6;
   localparam int T_HOFF = 7;
   localparam int T_TSD  = 3;
   localparam int T_UVL  = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic enable = 1'b0, therm = 1'b0, vin_low = 1'b1;
   logic [2:0] uv = 3'b111, ok = 3'b000, ovh = 3'b000, ovl = 3'b000;
   logic [2:0] rail_en, hs_off;
   logic softstart, power_ok;

   int checks = 0;
   int fails = 0;
   int cyc = 0;

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   rail_supervisor #(
      .N_RAIL(3), .PRESCALE(P), .T_SS(T_SS), .T_PG_DG(T_PGD), .T_RESET(T_RP),
      .T_HIC_ON(T_HON), .T_HIC_OFF(T_HOFF), .T_THERM_DG(T_TSD), .T_UVLO_DG(T_UVL)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .enable_i(enable), .therm_hot_i(therm),
      .vin_low_i(vin_low), .rail_uv_i(uv), .rail_ok_i(ok), .rail_ovh_i(ovh),
      .rail_ovl_i(ovl), .rail_en_o(rail_en), .hs_off_o(hs_off),
      .softstart_o(softstart), .power_ok_o(power_ok));

   function automatic int win_lo(int n, int lat);
      return (n - 1) * P + 1 + lat;
   endfunction
   function automatic int win_hi(int n, int lat);
      return n * P + lat;
   endfunction

   function automatic logic probe(int sel);
      case (sel)
         0:       return &rail_en;
         1:       return softstart;
         2:       return power_ok;
         default: return 1'b0;
      endcase
   endfunction

   task automatic check_val(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // Wait until a probed output reaches val; the elapsed clocks since t0 must be in [lo,hi].
   task automatic expect_at(input int sel, input logic val, input int t0,
                            input int lo, input int hi, input string tag);
      int el;
      while (probe(sel) !== val && (cyc - t0) <= hi + 4) @(negedge clk);
      el = cyc - t0;
      checks++;
      if (probe(sel) !== val || el < lo || el > hi) begin
         fails++;
         $display("FAIL %s: actual value %0b after %0d clocks, expected %0b within %0d..%0d clocks",
                  tag, probe(sel), el, val, lo, hi);
      end
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
      finish_run();
   end

   initial begin : stim
      int t0;
      int bad;
      repeat (3) @(negedge clk);
      // R1 reset state
      check_val("R1 rail_en in reset", rail_en, 0);
      check_val("R1 hs_off in reset", hs_off, 0);
      check_val("R1 softstart in reset", softstart, 0);
      check_val("R1 power_ok in reset", power_ok, 0);
      rst_n = 1'b1;

      // R9 start waits for input-low filter; R2 start-up
      @(negedge clk);
      vin_low = 1'b0; enable = 1'b1; t0 = cyc;
      expect_at(0, 1'b1, t0, win_lo(T_UVL, 1), win_hi(T_UVL, 1), "R9 start after input-low release");
      check_val("R2 all rails enabled together", rail_en, 7);
      check_val("R2 softstart during start", softstart, 1);
      uv = 3'b000; ok = 3'b111; t0 = cyc;
      expect_at(1, 1'b0, t0, win_lo(T_SS, 1), win_hi(T_SS, 1), "R2 soft-start length");
      t0 = cyc;
      expect_at(2, 1'b1, t0, win_lo(T_PGD + T_RP, 0), win_hi(T_PGD + T_RP, 0), "R3 power-good rise");

      // R8 short temperature pulse ignored
      @(negedge clk); therm = 1'b1;
      @(negedge clk); therm = 1'b0;
      bad = 0;
      for (int i = 0; i < 3 * T_TSD * P; i++) begin
         @(negedge clk);
         if (!power_ok || rail_en != 3'b111) bad++;
      end
      check_val("R8 short temperature pulse ignored", bad, 0);

      // R4 / R5 short undervoltage pulse ignored
      uv[1] = 1'b1; ok[1] = 1'b0;
      repeat (2) @(negedge clk);
      uv[1] = 1'b0; ok[1] = 1'b1;
      bad = 0;
      for (int i = 0; i < 3 * T_HON * P; i++) begin
         @(negedge clk);
         if (!power_ok) bad++;
      end
      check_val("R4 short low-rail pulse keeps power-good", bad, 0);
      check_val("R5 short low-rail pulse keeps rails on", rail_en, 7);

      // R7 overvoltage inhibit sweep over rails and flag combinations
      for (int r = 0; r < 3; r++) begin
         ovl[r] = 1'b1;
         repeat (2) @(negedge clk);
         check_val("R7 lower flag alone does not inhibit", hs_off, 0);
         ovh[r] = 1'b1;
         @(negedge clk);
         check_val("R7 inhibit one clock after upper flag", hs_off, 1 << r);
         ovh[r] = 1'b0;
         repeat (3) @(negedge clk);
         check_val("R7 inhibit held by lower flag", hs_off, 1 << r);
         ovl[r] = 1'b0;
         @(negedge clk);
         check_val("R7 inhibit released", hs_off, 0);
      end

      // R4 power-good fall, R5 hiccup, R6 restart
      uv[2] = 1'b1; ok[2] = 1'b0; t0 = cyc;
      expect_at(2, 1'b0, t0, win_lo(T_PGD, 1), win_hi(T_PGD, 1), "R4 power-good fall");
      expect_at(0, 1'b0, t0, win_lo(T_HON, 1), win_hi(T_HON, 1), "R5 hiccup shutdown");
      check_val("R5 all rails off in hiccup", rail_en, 0);
      uv[2] = 1'b0; ok[2] = 1'b1; t0 = cyc;
      expect_at(0, 1'b1, t0, win_lo(T_HOFF, 1), win_hi(T_HOFF, 1), "R6 hiccup off time");
      check_val("R6 restart enters soft-start", softstart, 1);
      t0 = cyc;
      expect_at(1, 1'b0, t0, win_lo(T_SS, 1), win_hi(T_SS, 1), "R6 restart soft-start length");
      t0 = cyc;
      expect_at(2, 1'b1, t0, win_lo(T_PGD + T_RP, 0), win_hi(T_PGD + T_RP, 0), "R3 power-good after restart");

      // R8 thermal shutdown and automatic restart
      therm = 1'b1; t0 = cyc;
      expect_at(0, 1'b0, t0, win_lo(T_TSD, 1), win_hi(T_TSD, 1), "R8 thermal shutdown");
      check_val("R8 power-good cleared by thermal", power_ok, 0);
      therm = 1'b0; t0 = cyc;
      expect_at(0, 1'b1, t0, win_lo(T_TSD, 1), win_hi(T_TSD, 1), "R8 thermal release restart");
      t0 = cyc;
      expect_at(1, 1'b0, t0, win_lo(T_SS, 1), win_hi(T_SS, 1), "R8 soft-start after thermal");
      t0 = cyc;
      expect_at(2, 1'b1, t0, win_lo(T_PGD + T_RP, 0), win_hi(T_PGD + T_RP, 0), "R3 power-good after thermal");

      // R10 enable drop
      enable = 1'b0;
      @(negedge clk);
      check_val("R10 rails off one clock after enable low", rail_en, 0);
      check_val("R10 power-good low one clock after enable low", power_ok, 0);
      repeat (4) @(negedge clk);
      check_val("R10 rails stay off while disabled", rail_en, 0);
      enable = 1'b1;
      @(negedge clk);
      check_val("R2 rails on one clock after enable high", rail_en, 7);

      // R9 input-low shutdown and release
      vin_low = 1'b1; t0 = cyc;
      expect_at(0, 1'b0, t0, win_lo(T_UVL, 1), win_hi(T_UVL, 1), "R9 input-low shutdown");
      vin_low = 1'b0; t0 = cyc;
      expect_at(0, 1'b1, t0, win_lo(T_UVL, 1), win_hi(T_UVL, 1), "R9 input-low release");

      finish_run();
   end
endmodule